// File: doc/BRIEF.md
# Pixel Color Component Extractor

This block sits at the end of a scanout path. Each cycle it receives one packed pixel word from the framebuffer fetch logic and produces an 8-bit red, green and blue value for the video stream. A small configuration port loads a pixel-size setting and one select word per color channel. The pixel-size setting gives the number of bytes of the word that belong to the pixel. Each select word gives the lowest bit of that channel's field, how many bits the field has, and a fallback color.

Fields narrower than eight bits are scaled up to the full output range by bit replication. A channel shows its fallback color when its bit count is zero, while the pixel lies outside the visible area, and while the upstream buffer has underrun. Setting the red fallback to 0xFF, for example, makes underruns visible as red. The outputs are registered with one cycle of latency, and the valid and blank markers come out on the same cycle as the pixel they belong to.

Top module: `pix_chan_unpack`

## Requirements
- R1: A write to address 0 loads the pixel size from cfgWrData[4:3], which holds bytes per pixel minus one (0 means one byte, 3 means four bytes). Word bits at index 8*bytes or above read as zero during extraction.
- R2: Writes to addresses 1, 2 and 3 load the red, green and blue select words. The fallback color is in cfgWrData[23:16], the bit count in [11:8] and the lowest bit index in [4:0]. A write to one channel leaves the other channels unchanged.
- R3: With a bit count of 8, the channel output equals word bits lsb+7 down to lsb. Bit positions above 31 read as zero.
- R4: With a bit count n between 1 and 7, the n-bit field is placed in the top n output bits, and the lower bits repeat the field again from its MSB downward (output bit 7-j = field bit n-1-(j mod n)).
- R5: A bit count above 8 behaves as a count of 8.
- R6: A bit count of zero makes that channel output its fallback color.
- R7: While pixBlank is high, every channel outputs its fallback color.
- R8: While underrun is high, every channel outputs its fallback color.
- R9: The color outputs, outValid and outBlank change on the clock edge after their inputs are presented. outValid and outBlank are pixValid and pixBlank delayed by one cycle.
- R10: After reset, all settings are zero (one byte per pixel, every count zero, every fallback 0) and all outputs are zero. A configuration write applies to pixels presented from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Setting select: 0 pixel size, 1 red, 2 green, 3 blue |
| cfgWrData | input | 32 | Configuration write data |
| pixWord | input | 32 | Packed pixel word |
| pixValid | input | 1 | Pixel word is valid |
| pixBlank | input | 1 | Pixel lies outside the visible area |
| underrun | input | 1 | Upstream buffer has no data for this pixel |
| redOut | output | 8 | Red component, registered |
| greenOut | output | 8 | Green component, registered |
| blueOut | output | 8 | Blue component, registered |
| outValid | output | 1 | pixValid delayed one cycle |
| outBlank | output | 1 | pixBlank delayed one cycle |

## Verification
The bench targets the following corner cases, each with the failure it exposes:
- Fields of 5 and 6 bits. A design without replication would leave the low output bits zero, so full-scale values never reach 0xFF.
- Fields that straddle the pixel width or the top of the word. A design that ignores the pixel size would leak bits of the neighbouring pixel into the output.
- Counts of zero and of fifteen. A design without a clamp would read past eight bits, and one without the zero-count fallback would drive a meaningless field.
- Blanking and underrun cycles mixed into live pixels, with configuration writes landing in the same cycle as pixels. A design that forces the fallback one cycle late or early, or applies a write to the pixel already in flight, would show the wrong color on exactly those boundary cycles.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int PCE_WORD_W = 32;
  localparam int PCE_CH_W   = 8;
  localparam int PCE_NUM_CH = 3;
  localparam int PCE_LSB_W  = $clog2(PCE_WORD_W);

  typedef struct packed {
    logic [PCE_CH_W-1:0]  dflt;
    logic [3:0]           cnt;
    logic [PCE_LSB_W-1:0] lsb;
  } chanSel_t;

  typedef struct packed {
    logic                  fmtWe;
    logic [PCE_NUM_CH-1:0] selWe;
    logic                  forceDflt;
  } ctrlStrb_t;
endpackage

// File: rtl/pce_ctrl.sv
module pce_ctrl
  import pce_pkg::*;
#(
  parameter int NUM_CH = PCE_NUM_CH
) (
  input  logic       cfgWrEn,
  input  logic [1:0] cfgAddr,
  input  logic       pixBlank,
  input  logic       underrun,
  output ctrlStrb_t  strb
);
  always_comb begin
    strb.fmtWe     = cfgWrEn && (cfgAddr == 2'd0);
    strb.forceDflt = pixBlank || underrun;
    for (int g = 0; g < NUM_CH; g++) begin
      strb.selWe[g] = cfgWrEn && (cfgAddr == 2'(g + 1));
    end
  end
endmodule

// File: rtl/pce_slice.sv
module pce_slice
  import pce_pkg::*;
#(
  parameter int WORD_W = PCE_WORD_W,
  parameter int CH_W   = PCE_CH_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        bytesM1,
  input  chanSel_t          sel,
  output logic [CH_W-1:0]   chanVal
);
  localparam int BIT_W = $clog2(WORD_W) + 2;

  logic [BIT_W-1:0]  validBits;
  logic [WORD_W-1:0] masked;
  logic [WORD_W-1:0] shifted;
  logic [3:0]        useCnt;
  logic [CH_W-1:0]   field;
  logic [CH_W-1:0]   expanded;

  always_comb begin
    validBits = BIT_W'(({{(BIT_W-2){1'b0}}, bytesM1} + BIT_W'(1)) << 3);
    for (int b = 0; b < WORD_W; b++) begin
      masked[b] = word[b] & (BIT_W'(b) < validBits);
    end
    shifted  = masked >> sel.lsb;
    useCnt   = (sel.cnt > 4'(CH_W)) ? 4'(CH_W) : sel.cnt;
    field    = shifted[CH_W-1:0];
    expanded = '0;
    if (useCnt != 4'd0) begin
      for (int j = 0; j < CH_W; j++) begin
        expanded[CH_W-1-j] = field[(int'(useCnt) - 1) - (j % int'(useCnt))];
      end
    end
    chanVal = (useCnt == 4'd0) ? sel.dflt : expanded;
  end
endmodule

// File: rtl/pce_datapath.sv
module pce_datapath
  import pce_pkg::*;
#(
  parameter int WORD_W = PCE_WORD_W,
  parameter int CH_W   = PCE_CH_W,
  parameter int NUM_CH = PCE_NUM_CH
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrb_t                    strb,
  input  logic [31:0]                  cfgWrData,
  input  logic [WORD_W-1:0]            pixWord,
  input  logic                         pixValid,
  input  logic                         pixBlank,
  output logic [NUM_CH-1:0][CH_W-1:0]  chanQ,
  output logic                         outValid,
  output logic                         outBlank
);
  logic [1:0] fmtReg;
  chanSel_t   selReg [NUM_CH];
  logic       unusedWrBits;

  assign unusedWrBits = ^{cfgWrData[31:24], cfgWrData[15:12], cfgWrData[7:5], cfgWrData[2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtReg   <= '0;
      outValid <= 1'b0;
      outBlank <= 1'b0;
    end else begin
      if (strb.fmtWe) fmtReg <= cfgWrData[4:3];
      outValid <= pixValid;
      outBlank <= pixBlank;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [CH_W-1:0] sliceVal;

    pce_slice #(.WORD_W(WORD_W), .CH_W(CH_W)) uSlice (
      .word    (pixWord),
      .bytesM1 (fmtReg),
      .sel     (selReg[g]),
      .chanVal (sliceVal)
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selReg[g] <= '0;
        chanQ[g]  <= '0;
      end else begin
        if (strb.selWe[g]) begin
          selReg[g].dflt <= cfgWrData[23:16];
          selReg[g].cnt  <= cfgWrData[11:8];
          selReg[g].lsb  <= cfgWrData[4:0];
        end
        chanQ[g] <= strb.forceDflt ? selReg[g].dflt : sliceVal;
      end
    end

    // R7 R8
    force_dflt_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pixBlank | strb.forceDflt) |=> (chanQ[g] == $past(selReg[g].dflt)));

    // R6
    zero_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
      (selReg[g].cnt == 4'd0) |=> (chanQ[g] == $past(selReg[g].dflt)));
  end

  // R9
  valid_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid);

  // R9
  invalid_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid);

  // R9
  blank_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixBlank |=> outBlank);
endmodule

// File: rtl/pix_chan_unpack.sv
module pix_chan_unpack
  import pce_pkg::*;
#(
  parameter int WORD_W = PCE_WORD_W,
  parameter int CH_W   = PCE_CH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [31:0]       cfgWrData,
  input  logic [WORD_W-1:0] pixWord,
  input  logic              pixValid,
  input  logic              pixBlank,
  input  logic              underrun,
  output logic [CH_W-1:0]   redOut,
  output logic [CH_W-1:0]   greenOut,
  output logic [CH_W-1:0]   blueOut,
  output logic              outValid,
  output logic              outBlank
);
  localparam int NUM_CH = PCE_NUM_CH;

  ctrlStrb_t                   strb;
  logic [NUM_CH-1:0][CH_W-1:0] chanQ;

  pce_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .pixBlank (pixBlank),
    .underrun (underrun),
    .strb     (strb)
  );

  pce_datapath #(.WORD_W(WORD_W), .CH_W(CH_W), .NUM_CH(NUM_CH)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgWrData (cfgWrData),
    .pixWord   (pixWord),
    .pixValid  (pixValid),
    .pixBlank  (pixBlank),
    .chanQ     (chanQ),
    .outValid  (outValid),
    .outBlank  (outBlank)
  );

  assign redOut   = chanQ[0];
  assign greenOut = chanQ[1];
  assign blueOut  = chanQ[2];
endmodule

// File: tb/pix_chan_unpack_test.sv
module pix_chan_unpack_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] pixWord = '0;
  logic        pixValid = 1'b0;
  logic        pixBlank = 1'b0;
  logic        underrun = 1'b0;
  logic [7:0]  redOut, greenOut, blueOut;
  logic        outValid, outBlank;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model settings
  int mFmt = 0;
  int mDflt[3] = '{0, 0, 0};
  int mCnt[3]  = '{0, 0, 0};
  int mLsb[3]  = '{0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_chan_unpack uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .pixWord(pixWord), .pixValid(pixValid),
    .pixBlank(pixBlank), .underrun(underrun), .redOut(redOut),
    .greenOut(greenOut), .blueOut(blueOut), .outValid(outValid),
    .outBlank(outBlank)
  );

  function automatic int modelChan(logic [31:0] w, int ch, bit bl, bit ur);
    int n, width, res;
    bit fld[8];
    if (bl || ur || mCnt[ch] == 0) return mDflt[ch];
    n = (mCnt[ch] > 8) ? 8 : mCnt[ch];
    width = (mFmt + 1) * 8;
    for (int k = 0; k < 8; k++) fld[k] = 0;
    for (int k = 0; k < n; k++) begin
      int idx = mLsb[ch] + k;
      fld[k] = (idx < width && idx < 32) ? w[idx] : 1'b0;
    end
    res = 0;
    for (int j = 0; j < 8; j++)
      if (fld[n - 1 - (j % n)]) res = res | (1 << (7 - j));
    return res;
  endfunction

  function automatic string tagFor(int ch, bit bl, bit ur);
    string nm;
    nm = (ch == 0) ? "R2 red" : (ch == 1) ? "R2 green" : "R2 blue";
    if (bl) return {nm, " R7"};
    if (ur) return {nm, " R8"};
    if (mCnt[ch] == 0) return {nm, " R6"};
    if (mLsb[ch] + ((mCnt[ch] > 8) ? 8 : mCnt[ch]) > (mFmt + 1) * 8) return {nm, " R1"};
    if (mCnt[ch] > 8) return {nm, " R5"};
    if (mCnt[ch] < 8) return {nm, " R4"};
    return {nm, " R3"};
  endfunction

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic [31:0] w, bit v, bit bl, bit ur,
                      bit we, logic [1:0] a, logic [31:0] d);
    int expCh[3];
    string tags[3];
    @(negedge clk);
    pixWord = w; pixValid = v; pixBlank = bl; underrun = ur;
    cfgWrEn = we; cfgAddr = a; cfgWrData = d;
    @(posedge clk);
    for (int c = 0; c < 3; c++) begin
      expCh[c] = modelChan(w, c, bl, ur);
      tags[c]  = tagFor(c, bl, ur);
    end
    // R10: write applies only to later pixels
    if (we) begin
      if (a == 2'd0) mFmt = int'(d[4:3]);
      else begin
        mDflt[a-1] = int'(d[23:16]);
        mCnt[a-1]  = int'(d[11:8]);
        mLsb[a-1]  = int'(d[4:0]);
      end
    end
    #(CLK_PERIOD/4);
    checkVal(tags[0], int'(redOut), expCh[0]);
    checkVal(tags[1], int'(greenOut), expCh[1]);
    checkVal(tags[2], int'(blueOut), expCh[2]);
    checkVal("R9 outValid", int'(outValid), int'(v));
    checkVal("R9 outBlank", int'(outBlank), int'(bl));
  endtask

  task automatic cfg(logic [1:0] a, logic [31:0] d);
    step(32'h0, 0, 0, 0, 1, a, d);
  endtask

  task automatic pixels(int num, int blankPct, int urPct);
    for (int i = 0; i < num; i++)
      step($urandom, 1, ($urandom % 100) < blankPct, ($urandom % 100) < urPct, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R10: reset state
    #(CLK_PERIOD * 3);
    checkVal("R10 reset red", int'(redOut), 0);
    checkVal("R10 reset green", int'(greenOut), 0);
    checkVal("R10 reset blue", int'(blueOut), 0);
    checkVal("R10 reset valid", int'(outValid), 0);
    @(negedge clk); rstN = 1'b1;
    // R10: zero settings give zero fallback
    step(32'hFFFF_FFFF, 1, 0, 0, 0, 0, 0);

    // 3 bytes, 8-8-8 (R3), red fallback 0xFF
    cfg(2'd0, 32'h0000_0010);
    cfg(2'd1, 32'h00FF_0810);
    cfg(2'd2, 32'h0000_0808);
    cfg(2'd3, 32'h0000_0800);
    step(32'h00AB_CDEF, 1, 0, 0, 0, 0, 0);
    pixels(20, 0, 0);

    // 2 bytes, 5-6-5 (R4)
    cfg(2'd0, 32'h0000_0008);
    cfg(2'd1, 32'h0011_050B);
    cfg(2'd2, 32'h0022_0605);
    cfg(2'd3, 32'h0033_0500);
    step(32'h0000_FFFF, 1, 0, 0, 0, 0, 0);
    step(32'h0000_8410, 1, 0, 0, 0, 0, 0);
    pixels(20, 0, 0);

    // blanking and underrun mixed (R7 R8)
    pixels(40, 25, 25);
    step(32'h0000_FFFF, 1, 1, 0, 0, 0, 0);
    step(32'h0000_FFFF, 1, 0, 1, 0, 0, 0);
    step(32'h0000_FFFF, 1, 0, 0, 0, 0, 0);

    // zero count (R6) and clamp (R5); write lands with a live pixel (R10)
    step(32'h1234_5678, 1, 0, 0, 1, 2'd2, 32'h005A_0003);
    step(32'h1234_5678, 1, 0, 0, 1, 2'd3, 32'h0000_0F04);
    cfg(2'd0, 32'h0000_0018);
    pixels(20, 0, 0);

    // width cut (R1) and top of word (R3)
    cfg(2'd0, 32'h0000_0000);
    cfg(2'd1, 32'h0000_0804);
    step(32'hFFFF_FFFF, 1, 0, 0, 0, 0, 0);
    cfg(2'd0, 32'h0000_0018);
    cfg(2'd1, 32'h0000_081C);
    step(32'hF000_0000, 1, 0, 0, 0, 0, 0);
    pixels(10, 0, 0);

    // long mixed run with random writes
    for (int i = 0; i < 2000; i++) begin
      bit we = (($urandom % 8) == 0);
      step($urandom, $urandom % 2, ($urandom % 10) == 0, ($urandom % 10) == 0,
           we, 2'($urandom % 4), $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule